// File: doc/BRIEF.md
# SDRAM Command Controller

This block turns single-byte host accesses into command sequences for an x8 synchronous DRAM with four banks. It splits the flat host address into a bank, a row and a column. For each request it opens the row, issues one READ or WRITE after the row-to-column delay, and then closes the bank. The bank is closed either by the auto-precharge flag on address line 10 or by a separate PRECHARGE, chosen per request. Read data is captured a programmable CAS latency after the READ, and a refresh timer sized from the clock frequency schedules AUTO REFRESH commands between accesses.

After reset the controller waits out a power-up period. It then precharges all banks, issues two refreshes and loads the mode register, and only after that does it offer `req_ready`. The memory is programmed for single-beat sequential bursts, so every access moves one byte. The data bus is split into an output, an output enable and an input, which lets the pad ring build the tristate buffer.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While `rst` is high the command pins carry NOP (`{cs_n,ras_n,cas_n,we_n}` = 4'b0111), and `req_ready`, `sd_dq_oe`, `sd_dqm` and `rd_valid` are low.
- R2: After reset only NOPs appear for at least INIT_CYCLES cycles. Then come, in order, PRECHARGE with A10 high, AUTO REFRESH, AUTO REFRESH and MODE REGISTER LOAD. The mode word holds CAS_LAT in A6:A4 and zero in every other bit, which selects single-beat sequential bursts; BA is 0. `req_ready` stays low until that sequence is complete. Command codes are MRS 0000, REF 0001, PRE 0010, ACT 0011, WR 0100 and RD 0101.
- R3: The host address maps as bank = `req_addr[22:21]`, row = `req_addr[20:9]` and column = `req_addr[8:0]`. An accepted request produces ACT with that bank on `sd_ba` and that row on `sd_addr` in the next cycle. The following READ or WRITE carries the column on A8:A0.
- R4: READ or WRITE follows its ACT by exactly T_RCD cycles.
- R5: With `req_autopre` high, the READ or WRITE has A10 high and no PRECHARGE follows. With it low, A10 is low and a PRECHARGE with A10 low to the same bank follows before the next ACT or refresh.
- R6: `rd_valid` is high for one cycle, CAS_LAT+1 cycles after the READ command is on the pins. `rd_data` then holds the byte the memory drove CAS_LAT edges after sampling the READ.
- R7: `sd_dq_oe` is high only during a WRITE command cycle, with `sd_dq_out` = `req_wdata`. `sd_dqm` equals `req_mask` in that cycle, so a masked write leaves the stored byte unchanged.
- R8: Outside a masked WRITE cycle `sd_dqm` is low, so the read output drivers are always enabled.
- R9: After initialisation, consecutive AUTO REFRESH commands are never more than one 64 ms/4096 interval apart (3906 cycles at 250 MHz).
- R10: While a refresh is pending, `req_ready` is low. AUTO REFRESH is issued only with all banks closed.
- R11: ACT goes only to a closed bank, and at least T_RP cycles after an explicit PRECHARGE of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | 1 = close the bank with auto-precharge |
| req_mask | input | 1 | Write byte mask (1 = do not store) |
| req_addr | input | 23 | Flat byte address: bank, row, column |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read byte |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / mode address, A10 = auto-precharge |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 8 | Data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 8 | Data from memory |

## Verification
The checker watches every cycle for five properties. It confirms that an accepted request turns into the matching ACT on the next cycle, and that data enable and mask appear only on WRITE cycles. It checks that each read-valid pulse sits exactly CAS_LAT+1 cycles behind a READ, that no request is taken before the mode load or while a refresh is pending, and that the gap between refreshes never grows past the interval. The bench's memory model and scenarios cover the rest: the init order and mode word, row-to-column spacing, PRECHARGE after non-auto-precharge accesses, bank-state legality, masked writes observed through readback, and refresh under continuous traffic.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;
    localparam int BANK_W  = 2;
    localparam int ROW_W   = 12;
    localparam int COL_W   = 9;
    localparam int DQ_W    = 8;
    localparam int HADDR_W = BANK_W + ROW_W + COL_W;
    localparam int AP_BIT  = 10;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_WAIT, ST_PREALL, ST_IREF, ST_MRS, ST_IDLE, ST_RW, ST_PRE
    } ctl_st_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } haddr_t;

    typedef struct packed {
        logic            we;
        logic            ap;
        logic            mask;
        logic [DQ_W-1:0] wdata;
        haddr_t          a;
    } hreq_t;

    // Refresh interval in clocks: 64 ms / 4096 = 15625 ns.
    function automatic int ref_nominal(input int mhz);
        return (mhz * 15625) / 1000;
    endfunction

    function automatic int ref_interval(input int mhz, input int margin);
        return ref_nominal(mhz) - margin;
    endfunction

    // Load value for the wait counter so that the next command lands t clocks later.
    function automatic int wait_load(input int t);
        return (t < 2) ? 0 : t - 2;
    endfunction

    // Mode word: single-beat burst, sequential, CAS latency in bits 6:4.
    function automatic logic [ROW_W-1:0] mode_word(input int cl);
        logic [ROW_W-1:0] m;
        m      = '0;
        m[6:4] = 3'(cl);
        return m;
    endfunction
endpackage

// File: rtl/sdrc_refresh_timer.sv
module sdrc_refresh_timer #(
    parameter int PERIOD = 3842
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int TW = $clog2(PERIOD + 1);

    logic [TW-1:0] cnt;
    logic          tick;

    assign tick = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= TW'(PERIOD - 1);
            pend <= 1'b0;
        end else begin
            if (en) begin
                cnt <= tick ? TW'(PERIOD - 1) : cnt - 1'b1;
            end
            if (tick) begin
                pend <= 1'b1;
            end else if (ack) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdrc_rd_pipe.sv
module sdrc_rd_pipe #(
    parameter int CAS_LAT = 3,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    // Stage k goes high k edges after the READ leaves the command register.
    // The memory samples READ one edge later and drives data CAS_LAT edges
    // after that, so data is taken when the last stage is set.
    logic [CAS_LAT-1:0] stage;

    generate
        if (CAS_LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= issue;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) stage <= '0;
                else     stage <= {stage[CAS_LAT-2:0], issue};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= stage[CAS_LAT-1];
            if (stage[CAS_LAT-1]) begin
                rd_data <= dq_in;
            end
        end
    end
endmodule

// File: rtl/sdrc_cmd_fsm.sv
module sdrc_cmd_fsm
    import sdrc_pkg::*;
#(
    parameter int CAS_LAT     = 3,
    parameter int T_RCD       = 2,
    parameter int T_RP        = 2,
    parameter int T_WR        = 2,
    parameter int T_RFC       = 8,
    parameter int T_MRD       = 2,
    parameter int INIT_CYCLES = 25000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  hreq_t             req,
    output logic              req_ready,
    input  logic              ref_pend,
    output logic              ref_ack,
    output logic              init_done,
    output sd_cmd_e           cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              dqm,
    output logic              rd_issue
);
    localparam int CNT_W   = $clog2(INIT_CYCLES + CAS_LAT + T_RP + T_WR + T_RFC + T_MRD + T_RCD + 2);
    localparam int L_INIT  = wait_load(INIT_CYCLES);
    localparam int L_RCD   = wait_load(T_RCD);
    localparam int L_RP    = wait_load(T_RP);
    localparam int L_RFC   = wait_load(T_RFC);
    localparam int L_MRD   = wait_load(T_MRD);
    localparam int L_WR    = wait_load(T_WR);
    localparam int L_WR_AP = wait_load(T_WR + T_RP);
    localparam int L_RD_AP = wait_load(CAS_LAT + T_RP);

    ctl_st_e          st, nxt;
    logic [CNT_W-1:0] cnt;
    logic             second_ref;
    hreq_t            cur;

    assign req_ready = (st == ST_IDLE) && !ref_pend;
    assign ref_ack   = (st == ST_IDLE) && ref_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_WAIT;
            nxt        <= ST_PREALL;
            cnt        <= CNT_W'(L_INIT);
            second_ref <= 1'b0;
            init_done  <= 1'b0;
            cur        <= '0;
            cmd        <= CMD_NOP;
            ba         <= '0;
            addr       <= '0;
            dq_out     <= '0;
            dq_oe      <= 1'b0;
            dqm        <= 1'b0;
            rd_issue   <= 1'b0;
        end else begin
            cmd      <= CMD_NOP;
            dq_oe    <= 1'b0;
            dqm      <= 1'b0;
            rd_issue <= 1'b0;
            case (st)
                ST_WAIT: begin
                    if (cnt == '0) st <= nxt;
                    else           cnt <= cnt - 1'b1;
                end
                ST_PREALL: begin
                    cmd          <= CMD_PRE;
                    addr         <= '0;
                    addr[AP_BIT] <= 1'b1;
                    cnt          <= CNT_W'(L_RP);
                    nxt          <= ST_IREF;
                    st           <= ST_WAIT;
                end
                ST_IREF: begin
                    cmd        <= CMD_REF;
                    second_ref <= 1'b1;
                    cnt        <= CNT_W'(L_RFC);
                    nxt        <= second_ref ? ST_MRS : ST_IREF;
                    st         <= ST_WAIT;
                end
                ST_MRS: begin
                    cmd       <= CMD_MRS;
                    ba        <= '0;
                    addr      <= mode_word(CAS_LAT);
                    init_done <= 1'b1;
                    cnt       <= CNT_W'(L_MRD);
                    nxt       <= ST_IDLE;
                    st        <= ST_WAIT;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        cmd <= CMD_REF;
                        cnt <= CNT_W'(L_RFC);
                        nxt <= ST_IDLE;
                        st  <= ST_WAIT;
                    end else if (req_valid) begin
                        cur  <= req;
                        cmd  <= CMD_ACT;
                        ba   <= req.a.bank;
                        addr <= req.a.row;
                        cnt  <= CNT_W'(L_RCD);
                        nxt  <= ST_RW;
                        st   <= ST_WAIT;
                    end
                end
                ST_RW: begin
                    cmd                <= cur.we ? CMD_WR : CMD_RD;
                    ba                 <= cur.a.bank;
                    addr               <= '0;
                    addr[COL_W-1:0]    <= cur.a.col;
                    addr[AP_BIT]       <= cur.ap;
                    if (cur.we) begin
                        dq_oe  <= 1'b1;
                        dq_out <= cur.wdata;
                        dqm    <= cur.mask;
                    end else begin
                        rd_issue <= 1'b1;
                    end
                    if (cur.ap) begin
                        cnt <= cur.we ? CNT_W'(L_WR_AP) : CNT_W'(L_RD_AP);
                        nxt <= ST_IDLE;
                        st  <= ST_WAIT;
                    end else if (cur.we) begin
                        cnt <= CNT_W'(L_WR);
                        nxt <= ST_PRE;
                        st  <= ST_WAIT;
                    end else begin
                        st <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    cmd  <= CMD_PRE;
                    addr <= '0;
                    cnt  <= CNT_W'(L_RP);
                    nxt  <= ST_IDLE;
                    st   <= ST_WAIT;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdrc_pkg::*;
#(
    parameter int CLK_MHZ     = 250,
    parameter int CAS_LAT     = 3,
    parameter int T_RCD       = 2,
    parameter int T_RP        = 2,
    parameter int T_WR        = 2,
    parameter int T_RFC       = 8,
    parameter int T_MRD       = 2,
    parameter int INIT_CYCLES = CLK_MHZ * 100,
    parameter int REF_MARGIN  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic               req_autopre,
    input  logic               req_mask,
    input  logic [HADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]    req_wdata,
    output logic               rd_valid,
    output logic [DQ_W-1:0]    rd_data,
    output logic               sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [BANK_W-1:0]  sd_ba,
    output logic [ROW_W-1:0]   sd_addr,
    output logic               sd_dqm,
    output logic [DQ_W-1:0]    sd_dq_out,
    output logic               sd_dq_oe,
    input  logic [DQ_W-1:0]    sd_dq_in
);
    localparam int REF_PERIOD = ref_interval(CLK_MHZ, REF_MARGIN);

    hreq_t   req;
    sd_cmd_e cmd;
    logic    ref_pend, ref_ack, init_done, rd_issue;

    assign req.we    = req_we;
    assign req.ap    = req_autopre;
    assign req.mask  = req_mask;
    assign req.wdata = req_wdata;
    assign req.a     = haddr_t'(req_addr);

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    sdrc_refresh_timer #(.PERIOD(REF_PERIOD)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .en   (init_done),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    sdrc_cmd_fsm #(
        .CAS_LAT     (CAS_LAT),
        .T_RCD       (T_RCD),
        .T_RP        (T_RP),
        .T_WR        (T_WR),
        .T_RFC       (T_RFC),
        .T_MRD       (T_MRD),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .req_ready (req_ready),
        .ref_pend  (ref_pend),
        .ref_ack   (ref_ack),
        .init_done (init_done),
        .cmd       (cmd),
        .ba        (sd_ba),
        .addr      (sd_addr),
        .dq_out    (sd_dq_out),
        .dq_oe     (sd_dq_oe),
        .dqm       (sd_dqm),
        .rd_issue  (rd_issue)
    );

    sdrc_rd_pipe #(.CAS_LAT(CAS_LAT), .DW(DQ_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .issue    (rd_issue),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/sdrc_checker.sv
module sdrc_checker
    import sdrc_pkg::*;
#(
    parameter int CAS_LAT   = 3,
    parameter int REF_LIMIT = 3906
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [HADDR_W-1:0] req_addr,
    input logic               sd_cs_n,
    input logic               sd_ras_n,
    input logic               sd_cas_n,
    input logic               sd_we_n,
    input logic [BANK_W-1:0]  sd_ba,
    input logic [ROW_W-1:0]   sd_addr,
    input logic               sd_dqm,
    input logic               sd_dq_oe,
    input logic               rd_valid,
    input logic               ref_pend
);
    logic [3:0]  pin_cmd;
    logic        init_seen;
    logic [31:0] ref_gap;

    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            init_seen <= 1'b0;
            ref_gap   <= '0;
        end else begin
            if (pin_cmd == CMD_MRS) init_seen <= 1'b1;
            if (pin_cmd == CMD_REF || pin_cmd == CMD_MRS) ref_gap <= '0;
            else                                         ref_gap <= ref_gap + 1;
        end
    end

    assert_accept_act_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (pin_cmd == CMD_ACT
            && sd_ba == $past(req_addr[HADDR_W-1 -: BANK_W])
            && sd_addr == $past(req_addr[COL_W +: ROW_W])));

    assert_oe_only_write_R7: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (pin_cmd == CMD_WR));

    assert_dqm_only_write_R8: assert property (@(posedge clk) disable iff (rst)
        sd_dqm |-> (pin_cmd == CMD_WR));

    assert_read_latency_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(pin_cmd == CMD_RD, CAS_LAT + 1));

    assert_no_accept_before_init_R2: assert property (@(posedge clk) disable iff (rst)
        !init_seen |-> !req_ready);

    assert_refresh_blocks_ready_R10: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> !req_ready);

    assert_refresh_gap_R9: assert property (@(posedge clk) disable iff (rst)
        init_seen |-> (ref_gap <= REF_LIMIT));
endmodule

bind sdram_cmd_ctrl sdrc_checker #(
    .CAS_LAT   (CAS_LAT),
    .REF_LIMIT (sdrc_pkg::ref_nominal(CLK_MHZ))
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .sd_dqm    (sd_dqm),
    .sd_dq_oe  (sd_dq_oe),
    .rd_valid  (rd_valid),
    .ref_pend  (ref_pend)
);

// File: tb/tb_sdram_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_cmd_ctrl;
    localparam int CL        = 3;
    localparam int TRCD      = 2;
    localparam int TRP       = 2;
    localparam int INIT      = 25000;
    localparam int REF_MAX   = 3906;   // 15625 ns at 250 MHz
    localparam int MODE_EXP  = CL << 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_we = 1'b0, req_autopre = 1'b0, req_mask = 1'b0;
    logic [22:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [7:0]  sd_dq_out;
    logic [7:0]  sd_dq_in = '0;

    always #2 clk = ~clk;

    sdram_cmd_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_autopre(req_autopre), .req_mask(req_mask),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    typedef struct {
        logic        we, ap, mask;
        logic [22:0] a;
        logic [7:0]  wd;
    } acc_t;

    int          n_chk = 0, n_fail = 0;
    int          cyc = 0, rel_cyc = 0;
    acc_t        acc_q[$];
    logic [7:0]  exp_q[$];
    logic [7:0]  shadow[int];
    logic [7:0]  mem[int];
    acc_t        cur;
    bit          open_b[4];
    int          pre_cyc[4];
    int          act_cyc = 0, rd_cyc = 0, rd_due = -1, last_ref = 0, init_idx = 0, n_ref = 0;
    logic [7:0]  rd_val = '0;
    bit          mrs_seen = 0, pre_pending = 0, done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] dflt(input int k);
        return 8'(k) ^ 8'(k >> 8) ^ 8'h5A;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Memory model, command monitor and scoreboard monitor.
    always @(negedge clk) begin
        logic [3:0] c;
        int k;
        cyc++;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        sd_dq_in = (cyc == rd_due) ? rd_val : 8'h00;
        if (rst) begin
            rel_cyc = cyc;
        end else begin
            if (!mrs_seen) chk(req_ready == 1'b0, "R2 ready before init", req_ready, 0);
            if (c != 4'b0111) begin
                if (c != 4'b0100) chk(!sd_dq_oe && !sd_dqm, "R8 dqm/oe off", {sd_dq_oe, sd_dqm}, 0);
                if (!mrs_seen) begin
                    case (init_idx)
                        0: begin
                            chk(c == 4'b0010 && sd_addr[10], "R2 precharge-all first", c, 2);
                            chk(cyc - rel_cyc >= INIT - 1, "R2 power-up wait", cyc - rel_cyc, INIT);
                        end
                        1, 2: chk(c == 4'b0001, "R2 init refresh", c, 1);
                        3: begin
                            chk(c == 4'b0000, "R2 mode load", c, 0);
                            chk(sd_addr == 12'(MODE_EXP) && sd_ba == 2'd0, "R2 mode word", sd_addr, MODE_EXP);
                            mrs_seen = 1;
                            last_ref = cyc;
                        end
                        default: chk(0, "R2 init order", c, 0);
                    endcase
                    init_idx++;
                end else begin
                    case (c)
                        4'b0011: begin
                            chk(!pre_pending, "R5 precharge missing before ACT", 1, 0);
                            chk(acc_q.size() > 0, "R3 ACT without request", 0, 1);
                            if (acc_q.size() > 0) cur = acc_q.pop_front();
                            chk(sd_ba == cur.a[22:21], "R3 ACT bank", sd_ba, cur.a[22:21]);
                            chk(sd_addr == cur.a[20:9], "R3 ACT row", sd_addr, cur.a[20:9]);
                            chk(!open_b[sd_ba], "R11 bank already open", 1, 0);
                            chk(cyc - pre_cyc[sd_ba] >= TRP, "R11 tRP", cyc - pre_cyc[sd_ba], TRP);
                            open_b[sd_ba] = 1;
                            act_cyc = cyc;
                        end
                        4'b0100, 4'b0101: begin
                            chk((c == 4'b0100) == cur.we, "R3 direction", c, cur.we);
                            chk(sd_ba == cur.a[22:21] && open_b[sd_ba], "R3 RW bank", sd_ba, cur.a[22:21]);
                            chk(sd_addr[8:0] == cur.a[8:0], "R3 column", sd_addr[8:0], cur.a[8:0]);
                            chk(sd_addr[10] == cur.ap, "R5 A10 flag", sd_addr[10], cur.ap);
                            chk(cyc - act_cyc == TRCD, "R4 tRCD", cyc - act_cyc, TRCD);
                            k = int'(cur.a);
                            if (c == 4'b0100) begin
                                chk(sd_dq_oe && sd_dq_out == cur.wd, "R7 write data", sd_dq_out, cur.wd);
                                chk(sd_dqm == cur.mask, "R7 write mask", sd_dqm, cur.mask);
                                if (!sd_dqm) mem[k] = sd_dq_out;
                            end else begin
                                rd_val = mem.exists(k) ? mem[k] : dflt(k);
                                rd_due = cyc + CL;
                                rd_cyc = cyc;
                            end
                            if (sd_addr[10]) open_b[sd_ba] = 0;
                            else             pre_pending = 1;
                        end
                        4'b0010: begin
                            chk(pre_pending && sd_ba == cur.a[22:21] && !sd_addr[10],
                                "R5 explicit precharge", sd_ba, cur.a[22:21]);
                            open_b[sd_ba] = 0;
                            pre_cyc[sd_ba] = cyc;
                            pre_pending = 0;
                        end
                        4'b0001: begin
                            chk(!open_b[0] && !open_b[1] && !open_b[2] && !open_b[3] && !pre_pending,
                                "R10 refresh with bank open", 1, 0);
                            chk(cyc - last_ref <= REF_MAX, "R9 refresh gap", cyc - last_ref, REF_MAX);
                            last_ref = cyc;
                            n_ref++;
                        end
                        default: chk(0, "R2 unexpected command", c, 7);
                    endcase
                end
            end
            if (rd_valid) begin
                chk(exp_q.size() > 0, "R6 unexpected read data", 1, 0);
                if (exp_q.size() > 0) begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R6 read data", rd_data, e);
                end
                chk(cyc - rd_cyc == CL + 1, "R6 read latency", cyc - rd_cyc, CL + 1);
            end
        end
        if (cyc > 150000 && !done) begin
            chk(0, "watchdog", cyc, 150000);
            finish_run();
        end
    end

    // Driver: presents one request and records what the scoreboard expects.
    task automatic access(input bit we, input bit ap, input bit mask,
                          input logic [22:0] a, input logic [7:0] wd);
        acc_t r;
        int k;
        r.we = we; r.ap = ap; r.mask = mask; r.a = a; r.wd = wd;
        k = int'(a);
        req_we = we; req_autopre = ap; req_mask = mask; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc_q.push_back(r);
        if (we && !mask) shadow[k] = wd;
        if (!we) exp_q.push_back(shadow.exists(k) ? shadow[k] : dflt(k));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [22:0] mk(input int b, input int r, input int c);
        return {2'(b), 12'(r), 9'(c)};
    endfunction

    initial begin
        int lfsr;
        for (int i = 0; i < 4; i++) pre_cyc[i] = -100;
        repeat (3) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 reset NOP",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
        chk(!req_ready && !sd_dq_oe && !sd_dqm && !rd_valid, "R1 reset outputs",
            {req_ready, sd_dq_oe, sd_dqm, rd_valid}, 0);
        rst = 1'b0;
        while (!req_ready) @(negedge clk);
        chk(init_idx == 4, "R2 init commands", init_idx, 4);

        // Corner addresses across all banks, both precharge styles.
        access(1, 1, 0, mk(0, 0, 0), 8'h11);
        access(1, 0, 0, mk(3, 4095, 511), 8'hEE);
        access(1, 1, 0, mk(1, 100, 7), 8'h3C);
        access(1, 0, 0, mk(2, 2048, 256), 8'hC3);
        access(0, 0, 0, mk(0, 0, 0), 8'h00);
        access(0, 1, 0, mk(3, 4095, 511), 8'h00);
        access(0, 0, 0, mk(1, 100, 7), 8'h00);
        access(0, 1, 0, mk(2, 2048, 256), 8'h00);
        // Masked write must not change the stored byte (R7).
        access(1, 0, 1, mk(1, 100, 7), 8'hFF);
        access(0, 1, 0, mk(1, 100, 7), 8'h00);
        access(1, 1, 1, mk(0, 0, 0), 8'h99);
        access(0, 0, 0, mk(0, 0, 0), 8'h00);
        // Unwritten location returns the memory's own contents.
        access(0, 1, 0, mk(2, 7, 77), 8'h00);
        // Same bank back to back, then continuous traffic across refreshes (R9, R10).
        access(1, 0, 0, mk(2, 7, 78), 8'h5E);
        access(0, 0, 0, mk(2, 7, 78), 8'h00);
        lfsr = 32'h1ACE;
        for (int i = 0; i < 700; i++) begin
            logic [22:0] a;
            lfsr = (lfsr << 1) ^ (((lfsr >> 22) ^ (lfsr >> 17)) & 1);
            a = 23'(lfsr);
            access(1, i[0], 0, a, 8'(lfsr >> 3));
            access(0, i[1], 0, a, 8'h00);
        end
        // Idle: refresh must keep going without traffic.
        repeat (4500) @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(n_ref >= 3, "R9 refresh count", n_ref, 3);
        chk(acc_q.size() == 0, "R3 all requests issued", acc_q.size(), 0);
        chk(!pre_pending, "R5 final precharge", pre_pending, 0);
        done = 1;
        finish_run();
    end
endmodule